// File: doc/BRIEF.md
# JTAG Test Access Port with Memory Bridge

This block is a serial test access port with a 4-bit instruction register. It holds a fixed 32-bit device identifier. It also acts as the single master of a classic handshake memory bus, so that an external debugger can read and write system memory word by word through the scan chain.

The debugger selects the address-load instruction and shifts in a word address. The shift-out of that scan returns the address that was loaded before it. Each later data scan under the read instruction or the read-write instruction moves one word and then steps the address by one. Bus cycles run in the system clock domain. A toggle synchronizer hands them over from the test clock domain. When an address is loaded, the block already fetches the word at that address, so the next data scan can shift it straight out.

Top module: `jtag_mem_tap`

## Requirements
- R1: Asserting `trst_n` low places the controller in its reset state and selects instruction 4'b0001. A data scan with no instruction load then shifts out 32'h000018FF, least significant bit first.
- R2: Every instruction scan shifts out the capture pattern 4'b0001, least significant bit first.
- R3: Two consecutive identifier reads return the same value.
- R4: Any instruction code other than 0001, 0101, 0110 and 0111 (including 0000 and 1111) selects a 1-bit bypass stage. It captures 0, so the output is the input delayed by one shift.
- R5: Instruction 0101 selects a 30-bit address register. Its scan loads the shifted-in word address and shifts out the address held before the load.
- R6: Instruction 0110 selects a 32-bit read register. Each scan shifts out the word at the current address, and on Update-DR the address advances by one.
- R7: Instruction 0111 selects a 32-bit read-write register. Each scan shifts out the word stored at the current address and writes the shifted-in word there. On Update-DR the address advances by one.
- R8: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. `tdo` and `tdo_oe` change on the falling edge of `tck`.
- R9: Bus cycles have `wb_cyc` equal to `wb_stb`. Address, data and `wb_we` hold steady until `wb_ack`. `wb_we` is high only for the write of a read-write access. Each hand-off ends with a read, after which the strobe drops.
- R10: Five consecutive `tck` rising edges with `tms` high bring the controller to its reset state from any state. This restores instruction 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | High while `tdo` carries shift data |
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous system reset, active high |
| wb_adr | output | ADDR_W | Bus word address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_we | output | 1 | Bus write enable |
| wb_stb | output | 1 | Bus strobe |
| wb_cyc | output | 1 | Bus cycle |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The bench builds the block with its defaults: a 30-bit address, a 32-bit data word and identifier 32'h000018FF. The test clock runs at one twentieth of the system clock, so every bus hand-off finishes well before the next Capture-DR. The bench uses a 16-word memory whose words differ from one another. With it, a full write, read-back and address-readout sequence starting at a low address shows both the address stepping and the prefetch of the next word.

// File: rtl/jtag_mem_tap.sv
`timescale 1ns/1ps
module jtag_mem_tap #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  parameter logic [31:0] IDCODE = 32'h000018FF
) (
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  input  logic              trst_n,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic              wb_we,
  output logic              wb_stb,
  output logic              wb_cyc,
  input  logic              wb_ack
);
  localparam int DR_W = (DATA_W > 32) ? DATA_W : 32;
  localparam logic [3:0] I_ID = 4'b0001, I_ADR = 4'b0101, I_RD = 4'b0110, I_RW = 4'b0111;
  localparam logic [3:0] S_TLR = 4'd0, S_RTI = 4'd1, S_SDS = 4'd2, S_CDR = 4'd3,
                         S_SDR = 4'd4, S_E1D = 4'd5, S_PDR = 4'd6, S_E2D = 4'd7,
                         S_UDR = 4'd8, S_SIS = 4'd9, S_CIR = 4'd10, S_SIR = 4'd11,
                         S_E1I = 4'd12, S_PIR = 4'd13, S_E2I = 4'd14, S_UIR = 4'd15;

  logic [3:0] st, nxt, ir, ir_sr;
  logic [DR_W-1:0] dr_sr, dr_nxt;
  logic [ADDR_W-1:0] addr, req_wadr, req_radr;
  logic [DATA_W-1:0] req_wdat, rd_q;
  logic req_we, req_tgl;
  int dr_len;

  always_comb begin
    case (st)
      S_TLR: nxt = tms ? S_TLR : S_RTI;
      S_RTI: nxt = tms ? S_SDS : S_RTI;
      S_SDS: nxt = tms ? S_SIS : S_CDR;
      S_CDR: nxt = tms ? S_E1D : S_SDR;
      S_SDR: nxt = tms ? S_E1D : S_SDR;
      S_E1D: nxt = tms ? S_UDR : S_PDR;
      S_PDR: nxt = tms ? S_E2D : S_PDR;
      S_E2D: nxt = tms ? S_UDR : S_SDR;
      S_UDR: nxt = tms ? S_SDS : S_RTI;
      S_SIS: nxt = tms ? S_TLR : S_CIR;
      S_CIR: nxt = tms ? S_E1I : S_SIR;
      S_SIR: nxt = tms ? S_E1I : S_SIR;
      S_E1I: nxt = tms ? S_UIR : S_PIR;
      S_PIR: nxt = tms ? S_E2I : S_PIR;
      S_E2I: nxt = tms ? S_UIR : S_SIR;
      default: nxt = tms ? S_SDS : S_RTI;
    endcase
  end

  wire in_tlr   = (st == S_TLR);
  wire in_shift = (st == S_SDR) || (st == S_SIR);
  wire upd_mem  = (st == S_UDR) && (ir == I_RD || ir == I_RW);

  always_comb begin
    case (ir)
      I_ID:         dr_len = 32;
      I_ADR:        dr_len = ADDR_W;
      I_RD, I_RW:   dr_len = DATA_W;
      default:      dr_len = 1;
    endcase
    for (int i = 0; i < DR_W; i++)
      dr_nxt[i] = (i == dr_len - 1) ? tdi : (i < dr_len - 1) ? dr_sr[(i + 1) % DR_W] : 1'b0;
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      st <= S_TLR; ir <= I_ID; ir_sr <= '0; dr_sr <= '0; addr <= '0;
      req_we <= 1'b0; req_tgl <= 1'b0; req_wadr <= '0; req_radr <= '0; req_wdat <= '0;
    end else begin
      st <= nxt;
      if (in_tlr) ir <= I_ID;
      else if (st == S_UIR) ir <= ir_sr;
      if (st == S_CIR) ir_sr <= 4'b0001;
      else if (st == S_SIR) ir_sr <= {tdi, ir_sr[3:1]};
      if (st == S_CDR)
        case (ir)
          I_ID:       dr_sr <= DR_W'(IDCODE);
          I_ADR:      dr_sr <= DR_W'(addr);
          I_RD, I_RW: dr_sr <= DR_W'(rd_q);
          default:    dr_sr <= '0;
        endcase
      else if (st == S_SDR) dr_sr <= dr_nxt;
      if (st == S_UDR)
        case (ir)
          I_ADR: begin
            addr <= dr_sr[ADDR_W-1:0]; req_radr <= dr_sr[ADDR_W-1:0];
            req_we <= 1'b0; req_tgl <= ~req_tgl;
          end
          I_RD, I_RW: begin
            addr <= addr + 1'b1; req_radr <= addr + 1'b1; req_wadr <= addr;
            req_wdat <= dr_sr[DATA_W-1:0]; req_we <= (ir == I_RW); req_tgl <= ~req_tgl;
          end
          default: ;
        endcase
    end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo <= 1'b0; tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift;
      tdo    <= (st == S_SIR) ? ir_sr[0] : dr_sr[0];
    end

  logic [2:0] tsync;
  logic [1:0] bst;
  wire go = tsync[2] ^ tsync[1];
  assign wb_cyc = wb_stb;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      tsync <= '0; bst <= 2'd0; wb_stb <= 1'b0; wb_we <= 1'b0;
      wb_adr <= '0; wb_dat_o <= '0; rd_q <= '0;
    end else begin
      tsync <= {tsync[1:0], req_tgl};
      case (bst)
        2'd0: if (go) begin
          wb_stb <= 1'b1; wb_we <= req_we; wb_dat_o <= req_wdat;
          wb_adr <= req_we ? req_wadr : req_radr;
          bst    <= req_we ? 2'd1 : 2'd2;
        end
        2'd1: if (wb_ack) begin
          wb_we <= 1'b0; wb_adr <= req_radr; bst <= 2'd2;
        end
        default: if (wb_ack) begin
          rd_q <= wb_dat_i; wb_stb <= 1'b0; bst <= 2'd0;
        end
      endcase
    end
endmodule

// File: rtl/jtag_mem_tap_chk.sv
`timescale 1ns/1ps
module jtag_mem_tap_chk #(
  parameter int ADDR_W = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              tck,
  input logic              trst_n,
  input logic              tms,
  input logic              tdo_oe,
  input logic              in_shift,
  input logic              in_tlr,
  input logic [3:0]        ir,
  input logic              upd_data,
  input logic [ADDR_W-1:0] addr,
  input logic              wb_stb,
  input logic              wb_ack,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_adr
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) ones <= '0;
    else ones <= tms ? ((ones == 3'd7) ? ones : ones + 3'd1) : 3'd0;

  AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
    (ones >= 3'd5) |-> in_tlr); // R10
  AST_TLR_SELECTS_ID: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr |=> (ir == 4'b0001)); // R1
  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> in_shift); // R8
  AST_ADDR_STEP: assert property (@(posedge tck) disable iff (!trst_n)
    upd_data |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R6
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we))); // R9
  AST_READ_ENDS: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_ack && !wb_we) |=> !wb_stb); // R9
endmodule

bind jtag_mem_tap jtag_mem_tap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tck(tck), .trst_n(trst_n), .tms(tms), .tdo_oe(tdo_oe),
  .in_shift(in_shift), .in_tlr(in_tlr), .ir(ir), .upd_data(upd_mem), .addr(addr),
  .wb_stb(wb_stb), .wb_ack(wb_ack), .wb_we(wb_we), .wb_adr(wb_adr)
);

// File: tb/tb_jtag_mem_tap.sv
`timescale 1ns/1ps
module tb_jtag_mem_tap;
  localparam int TH = 100;
  logic clk = 0, rst = 1, tck = 0, tms = 1, tdi = 0, trst_n = 0;
  logic tdo, tdo_oe, wb_we, wb_stb, wb_cyc, wb_ack = 0;
  logic [29:0] wb_adr;
  logic [31:0] wb_dat_o, wb_dat_i;
  logic [31:0] mem [16];
  int vec = 0, bad = 0;

  always #5 clk = ~clk;

  jtag_mem_tap dut (.tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo), .tdo_oe(tdo_oe),
    .clk(clk), .rst(rst), .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_we(wb_we), .wb_stb(wb_stb), .wb_cyc(wb_cyc), .wb_ack(wb_ack));

  assign wb_dat_i = mem[wb_adr[3:0]];
  always @(posedge clk) begin
    wb_ack <= wb_stb && !wb_ack;
    if (wb_stb && wb_ack && wb_we) mem[wb_adr[3:0]] <= wb_dat_o;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    #TH tck = 1;
    #TH tck = 0;
    #1;
  endtask

  task automatic scan_ir(input logic [3:0] din, output logic [3:0] dout);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      dout[i] = tdo;
      tick(i == 3, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    check("R8 oe in shift", {31'd0, tdo_oe}, 32'd1);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
    for (int k = 0; k < 4; k++) tick(0, 0);
    check("R8 oe idle", {31'd0, tdo_oe}, 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] o;
    check("R8 oe after reset", {31'd0, tdo_oe}, 32'd0);
    check("R9 no bus after reset", {31'd0, wb_stb}, 32'd0);
    tick(0, 0);
    scan_dr(32, 32'h0, o);
    check("R1 idcode after trst", o, 32'h000018FF);
  endtask

  task automatic t_idcode;
    logic [3:0] c; logic [31:0] a, b;
    scan_ir(4'b0001, c);
    check("R2 ir capture", {28'd0, c}, 32'h1);
    scan_dr(32, 32'hFFFF_FFFF, a);
    scan_dr(32, 32'h0, b);
    check("R3 first read", a, 32'h000018FF);
    check("R3 repeat read", b, a);
  endtask

  task automatic t_bypass;
    logic [3:0] c; logic [31:0] o;
    scan_ir(4'b1111, c);
    check("R2 ir capture", {28'd0, c}, 32'h1);
    scan_dr(8, 32'hB2, o);
    check("R4 bypass 1111", o, 32'h64);
    scan_ir(4'b0000, c);
    scan_dr(8, 32'h5B, o);
    check("R4 bypass 0000", o, 32'hB6);
  endtask

  task automatic t_memory;
    logic [3:0] c; logic [31:0] o;
    scan_ir(4'b0101, c);
    scan_dr(30, 32'd1, o);
    check("R5 prior addr", o, 32'd0);
    scan_ir(4'b0110, c);
    scan_dr(32, 32'h0, o);
    check("R6 read word 1", o, 32'hA000_0001);
    scan_dr(32, 32'h0, o);
    check("R6 read word 2", o, 32'hA000_0002);
    scan_ir(4'b0101, c);
    scan_dr(30, 32'd5, o);
    check("R5 addr stepped to 3", o, 32'd3);
    scan_ir(4'b0111, c);
    scan_dr(32, 32'h5555_5555, o);
    check("R7 old word 5", o, 32'hA000_0005);
    scan_dr(32, 32'hAAAA_AAAA, o);
    check("R7 old word 6", o, 32'hA000_0006);
    check("R7 mem 5 written", mem[5], 32'h5555_5555);
    check("R7 mem 6 written", mem[6], 32'hAAAA_AAAA);
    check("R9 neighbour untouched", mem[7], 32'hA000_0007);
    scan_ir(4'b0101, c);
    scan_dr(30, 32'd5, o);
    check("R5 addr stepped to 7", o, 32'd7);
    scan_ir(4'b0110, c);
    scan_dr(32, 32'h0, o);
    check("R6 readback 5", o, 32'h5555_5555);
    scan_dr(32, 32'h0, o);
    check("R6 readback 6", o, 32'hAAAA_AAAA);
  endtask

  task automatic t_tms_reset;
    logic [3:0] c; logic [31:0] o;
    scan_ir(4'b0101, c);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 5; k++) tick(1, 0);
    tick(0, 0);
    scan_dr(32, 32'h0, o);
    check("R10 tms reset restores idcode", o, 32'h000018FF);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
    #95 rst = 0; trst_n = 1;
    #20;
    t_reset;
    t_idcode;
    t_bypass;
    t_memory;
    t_tms_reset;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    vec++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule